// File: doc/BRIEF.md
# Sample-to-flash byte writer

This block takes 32-bit stereo capture words and stores them, one byte at a time, in a byte-wide NAND-style flash device. Each word holds a left channel in its upper half and a right channel in its lower half. The block sends four byte programs per word, in a fixed order, to consecutive flash addresses. It keeps a linear byte address that starts at zero and wraps around at the end of the device.

Every flash operation goes over one 8-bit output port. A command byte is sent with the command strobe high. Address bytes follow with the address strobe high, then the data byte, then a confirm command. After each confirm the block waits until the device's ready line reports idle. When the next write falls on the first byte of a 1 KB block, the block first erases that block and waits for it. Erase returns every byte of the block to 0xFF.

A small input FIFO absorbs the capture words that arrive while an erase or a program is in progress. If a word arrives while the FIFO is full, the word is dropped and a sticky overflow flag is set.

Top module: `smp_flash_writer`

## Requirements
- R1: The four bytes of a word go to four consecutive addresses in this order: bits 31:24 (left high), 23:16 (left low), 15:8 (right high), 7:0 (right low).
- R2: The first byte goes to address 0. Each programmed byte goes to the previous address plus one, modulo 2^ADDR_W.
- R3: A byte program is the command 0x80, then ceil(ADDR_W/8) address bytes with the least significant byte first, then one data byte, then the command 0x10.
- R4: Before the first program to an address whose low BLK_W bits are zero, the block erases that block. The erase is the command 0x60, then the address bytes of the block base, then the command 0xD0. No byte is programmed into a block that has not been erased since its last write. There is exactly one erase each time the writes reach a block.
- R5: No write-enable pulse begins while the ready input is low, or within GUARD cycles after a confirm cycle ends.
- R6: The command strobe is high only in command cycles, and the address strobe only in address cycles. The two strobes are never high together. The output enable is high whenever write-enable is low.
- R7: Write-enable is low for exactly WE_LOW cycles per bus cycle and then high for at least WE_HIGH cycles. The output byte stays stable while write-enable is low.
- R8: Up to FIFO_DEPTH words can wait while one word is being written. A word presented while the FIFO is full is never written, and it sets the overflow flag. The flag stays set until reset.
- R9: During and right after reset, write-enable is high, both strobes and the output enable are low, and the overflow flag is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Capture word present this cycle |
| smp_data | input | 32 | Capture word: left channel in 31:16, right channel in 15:0 |
| fl_io | output | 8 | Byte to the flash (command, address or data) |
| fl_io_oe | output | 1 | Drive enable for fl_io |
| fl_cle | output | 1 | Command strobe |
| fl_ale | output | 1 | Address strobe |
| fl_we_n | output | 1 | Write-enable, active low; the flash latches on its rising edge |
| fl_rdy | input | 1 | Flash ready (high) or busy (low) |
| ovf_flag | output | 1 | Sticky input overflow |

## Verification
The hardest situation to reach is the address wrap at the end of the device. There, block 0 must be erased again and its earlier contents replaced, while the later blocks still hold the first pass. A second hard situation is a burst that meets a full FIFO just as a new block begins.

The bench shrinks the device to 1 KB with 32-byte blocks, so that a full pass plus a partial second pass covers every block boundary and the wrap. It then sends a back-to-back burst, so that the overflow arrives while the erase of a fresh block is in progress. A flash model in the bench checks the final contents of every address against an arithmetic prediction. That prediction includes the bytes of the erased block that were never written again.

// File: rtl/sfw_pkg.sv
package sfw_pkg;

    localparam logic [7:0] CMD_PROG_OPEN  = 8'h80;
    localparam logic [7:0] CMD_PROG_GO    = 8'h10;
    localparam logic [7:0] CMD_ERASE_OPEN = 8'h60;
    localparam logic [7:0] CMD_ERASE_GO   = 8'hD0;

    typedef enum logic [1:0] {
        LANE_DATA,
        LANE_CMD,
        LANE_ADDR
    } lane_e;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_LOW,
        PH_HIGH
    } phase_e;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ER_CMD,
        ST_ER_ADR,
        ST_ER_GO,
        ST_PG_CMD,
        ST_PG_ADR,
        ST_PG_DAT,
        ST_PG_GO,
        ST_WAIT
    } seq_st_e;

endpackage

// File: rtl/sfw_fifo.sv
module sfw_fifo #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head,
    output logic         empty,
    output logic         ovf
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           rp;
        logic [PW-1:0]           wp;
        logic [CW-1:0]           cnt;
        logic                    ovf;
    } fifo_st_t;

    fifo_st_t q, d;
    logic full, take, give;

    always_comb begin
        d    = q;
        full = (q.cnt == CW'(DEPTH));
        give = pop && (q.cnt != '0);
        take = push && (!full || give);
        if (take) begin
            d.mem[q.wp] = push_data;
            d.wp        = (q.wp == PW'(DEPTH - 1)) ? '0 : q.wp + 1'b1;
        end
        if (give) begin
            d.rp = (q.rp == PW'(DEPTH - 1)) ? '0 : q.rp + 1'b1;
        end
        case ({take, give})
            2'b10:   d.cnt = q.cnt + 1'b1;
            2'b01:   d.cnt = q.cnt - 1'b1;
            default: d.cnt = q.cnt;
        endcase
        if (push && !take) begin
            d.ovf = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign head  = q.mem[q.rp];
    assign empty = (q.cnt == '0);
    assign ovf   = q.ovf;

endmodule

// File: rtl/sfw_bus.sv
module sfw_bus
    import sfw_pkg::*;
#(
    parameter int WE_LOW  = 2,
    parameter int WE_HIGH = 1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] in_byte,
    input  lane_e      in_lane,
    output logic       ready,
    output logic [7:0] io,
    output logic       io_oe,
    output logic       cle,
    output logic       ale,
    output logic       we_n
);
    localparam int WMAX = (WE_LOW > WE_HIGH) ? WE_LOW : WE_HIGH;
    localparam int TW   = $clog2(WMAX + 1);

    typedef struct packed {
        phase_e        ph;
        logic [TW-1:0] cnt;
        logic [7:0]    io;
        logic          oe;
        logic          cle;
        logic          ale;
        logic          we_n;
    } bus_st_t;

    bus_st_t q, d;

    always_comb begin
        d = q;
        case (q.ph)
            PH_IDLE: begin
                if (start) begin
                    d.ph   = PH_LOW;
                    d.cnt  = TW'(WE_LOW - 1);
                    d.io   = in_byte;
                    d.oe   = 1'b1;
                    d.cle  = (in_lane == LANE_CMD);
                    d.ale  = (in_lane == LANE_ADDR);
                    d.we_n = 1'b0;
                end
            end
            PH_LOW: begin
                if (q.cnt == '0) begin
                    d.ph   = PH_HIGH;
                    d.cnt  = TW'(WE_HIGH - 1);
                    d.we_n = 1'b1;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            PH_HIGH: begin
                if (q.cnt == '0) begin
                    d.ph  = PH_IDLE;
                    d.oe  = 1'b0;
                    d.cle = 1'b0;
                    d.ale = 1'b0;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            default: d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.ph   <= PH_IDLE;
            q.we_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign ready = (q.ph == PH_IDLE);
    assign io    = q.io;
    assign io_oe = q.oe;
    assign cle   = q.cle;
    assign ale   = q.ale;
    assign we_n  = q.we_n;

endmodule

// File: rtl/sfw_seq.sv
module sfw_seq
    import sfw_pkg::*;
#(
    parameter int ADDR_W = 25,
    parameter int BLK_W  = 10,
    parameter int GUARD  = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        fifo_empty,
    input  logic [31:0] fifo_head,
    output logic        fifo_pop,
    input  logic        bus_ready,
    output logic        bus_start,
    output logic [7:0]  bus_byte,
    output lane_e       bus_lane,
    input  logic        rdy
);
    localparam int ABYTES = (ADDR_W + 7) / 8;
    localparam int ABW    = (ABYTES > 1) ? $clog2(ABYTES) : 1;
    localparam int GW     = $clog2(GUARD + 1);

    typedef struct packed {
        seq_st_e           st;
        logic              erase_ret;
        logic [31:0]       sample;
        logic [1:0]        bsel;
        logic [ABW-1:0]    ai;
        logic [ADDR_W-1:0] addr;
        logic [GW-1:0]     guard;
    } seq_q_t;

    seq_q_t q, d;

    logic [ABYTES*8-1:0] addr_ext;
    logic [ABYTES*8-1:0] base_ext;
    logic [7:0]          smp_byte;
    logic [ADDR_W-1:0]   addr_inc;
    logic                at_blk_start;
    logic                inc_blk_start;
    logic                last_ab;

    always_comb begin
        addr_ext                  = '0;
        addr_ext[ADDR_W-1:0]      = q.addr;
        base_ext                  = addr_ext;
        base_ext[BLK_W-1:0]       = '0;
        addr_inc                  = q.addr + ADDR_W'(1);
        at_blk_start              = (q.addr[BLK_W-1:0] == '0);
        inc_blk_start             = (addr_inc[BLK_W-1:0] == '0);
        last_ab                   = (q.ai == ABW'(ABYTES - 1));
        case (q.bsel)
            2'd0:    smp_byte = q.sample[31:24];
            2'd1:    smp_byte = q.sample[23:16];
            2'd2:    smp_byte = q.sample[15:8];
            default: smp_byte = q.sample[7:0];
        endcase
    end

    always_comb begin
        d         = q;
        fifo_pop  = 1'b0;
        bus_start = 1'b0;
        bus_byte  = 8'h00;
        bus_lane  = LANE_DATA;
        case (q.st)
            ST_IDLE: begin
                if (!fifo_empty) begin
                    fifo_pop = 1'b1;
                    d.sample = fifo_head;
                    d.bsel   = 2'd0;
                    d.st     = at_blk_start ? ST_ER_CMD : ST_PG_CMD;
                end
            end
            ST_ER_CMD: begin
                bus_byte  = CMD_ERASE_OPEN;
                bus_lane  = LANE_CMD;
                bus_start = bus_ready;
                if (bus_ready) begin
                    d.st = ST_ER_ADR;
                    d.ai = '0;
                end
            end
            ST_ER_ADR: begin
                bus_byte  = base_ext[8*q.ai +: 8];
                bus_lane  = LANE_ADDR;
                bus_start = bus_ready;
                if (bus_ready) begin
                    if (last_ab) d.st = ST_ER_GO;
                    else         d.ai = q.ai + 1'b1;
                end
            end
            ST_ER_GO: begin
                bus_byte  = CMD_ERASE_GO;
                bus_lane  = LANE_CMD;
                bus_start = bus_ready;
                if (bus_ready) begin
                    d.st        = ST_WAIT;
                    d.erase_ret = 1'b1;
                    d.guard     = GW'(GUARD);
                end
            end
            ST_PG_CMD: begin
                bus_byte  = CMD_PROG_OPEN;
                bus_lane  = LANE_CMD;
                bus_start = bus_ready;
                if (bus_ready) begin
                    d.st = ST_PG_ADR;
                    d.ai = '0;
                end
            end
            ST_PG_ADR: begin
                bus_byte  = addr_ext[8*q.ai +: 8];
                bus_lane  = LANE_ADDR;
                bus_start = bus_ready;
                if (bus_ready) begin
                    if (last_ab) d.st = ST_PG_DAT;
                    else         d.ai = q.ai + 1'b1;
                end
            end
            ST_PG_DAT: begin
                bus_byte  = smp_byte;
                bus_lane  = LANE_DATA;
                bus_start = bus_ready;
                if (bus_ready) d.st = ST_PG_GO;
            end
            ST_PG_GO: begin
                bus_byte  = CMD_PROG_GO;
                bus_lane  = LANE_CMD;
                bus_start = bus_ready;
                if (bus_ready) begin
                    d.st        = ST_WAIT;
                    d.erase_ret = 1'b0;
                    d.guard     = GW'(GUARD);
                end
            end
            ST_WAIT: begin
                if (bus_ready) begin
                    if (q.guard != '0) begin
                        d.guard = q.guard - 1'b1;
                    end else if (rdy) begin
                        if (q.erase_ret) begin
                            d.erase_ret = 1'b0;
                            d.st        = ST_PG_CMD;
                        end else begin
                            d.addr = addr_inc;
                            if (q.bsel == 2'd3) begin
                                d.st = ST_IDLE;
                            end else begin
                                d.bsel = q.bsel + 1'b1;
                                d.st   = inc_blk_start ? ST_ER_CMD : ST_PG_CMD;
                            end
                        end
                    end
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/smp_flash_writer.sv
module smp_flash_writer
    import sfw_pkg::*;
#(
    parameter int ADDR_W     = 25,
    parameter int BLK_W      = 10,
    parameter int FIFO_DEPTH = 4,
    parameter int WE_LOW     = 2,
    parameter int WE_HIGH    = 1,
    parameter int GUARD      = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        smp_valid,
    input  logic [31:0] smp_data,
    output logic [7:0]  fl_io,
    output logic        fl_io_oe,
    output logic        fl_cle,
    output logic        fl_ale,
    output logic        fl_we_n,
    input  logic        fl_rdy,
    output logic        ovf_flag
);
    logic        f_empty;
    logic [31:0] f_head;
    logic        f_pop;
    logic        b_ready;
    logic        b_start;
    logic [7:0]  b_byte;
    lane_e       b_lane;

    sfw_fifo #(
        .W     (32),
        .DEPTH (FIFO_DEPTH)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (smp_valid),
        .push_data (smp_data),
        .pop       (f_pop),
        .head      (f_head),
        .empty     (f_empty),
        .ovf       (ovf_flag)
    );

    sfw_seq #(
        .ADDR_W (ADDR_W),
        .BLK_W  (BLK_W),
        .GUARD  (GUARD)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (f_empty),
        .fifo_head  (f_head),
        .fifo_pop   (f_pop),
        .bus_ready  (b_ready),
        .bus_start  (b_start),
        .bus_byte   (b_byte),
        .bus_lane   (b_lane),
        .rdy        (fl_rdy)
    );

    sfw_bus #(
        .WE_LOW  (WE_LOW),
        .WE_HIGH (WE_HIGH)
    ) u_bus (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (b_start),
        .in_byte (b_byte),
        .in_lane (b_lane),
        .ready   (b_ready),
        .io      (fl_io),
        .io_oe   (fl_io_oe),
        .cle     (fl_cle),
        .ale     (fl_ale),
        .we_n    (fl_we_n)
    );

endmodule

// File: rtl/sfw_chk.sv
module sfw_chk #(
    parameter int WE_LOW = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       fl_we_n,
    input logic       fl_cle,
    input logic       fl_ale,
    input logic       fl_io_oe,
    input logic [7:0] fl_io,
    input logic       fl_rdy,
    input logic       ovf_flag
);
    logic [15:0] low_run_q;

    always_ff @(posedge clk) begin
        if (!rst_n)       low_run_q <= '0;
        else if (fl_we_n) low_run_q <= '0;
        else              low_run_q <= low_run_q + 16'd1;
    end

    a_r6_strobe_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_cle && fl_ale));

    a_r6_oe_while_we: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> fl_io_oe);

    a_r7_we_width: assert property (@(posedge clk) disable iff (!rst_n)
        !fl_we_n |-> (low_run_q < 16'(WE_LOW)));

    a_r7_io_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!fl_we_n && !$past(fl_we_n)) |-> $stable(fl_io));

    a_r5_no_pulse_busy: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(fl_we_n) |-> fl_rdy);

    a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_flag |=> ovf_flag);

endmodule

bind smp_flash_writer sfw_chk #(.WE_LOW(WE_LOW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .fl_we_n  (fl_we_n),
    .fl_cle   (fl_cle),
    .fl_ale   (fl_ale),
    .fl_io_oe (fl_io_oe),
    .fl_io    (fl_io),
    .fl_rdy   (fl_rdy),
    .ovf_flag (ovf_flag)
);

// File: tb/sim_smp_flash_writer.sv
module sim_smp_flash_writer;
    localparam int CLK_P   = 10;
    localparam int AW      = 10;
    localparam int BW      = 5;
    localparam int DEPTH   = 4;
    localparam int WL      = 2;
    localparam int WH      = 1;
    localparam int GRD     = 2;
    localparam int MEMSZ   = 1 << AW;
    localparam int ABYTES  = (AW + 7) / 8;
    localparam int BUSYCYC = 5;
    localparam int WDOG    = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        smp_valid = 1'b0;
    logic [31:0] smp_data = '0;
    logic [7:0]  fl_io;
    logic        fl_io_oe, fl_cle, fl_ale, fl_we_n, ovf_flag;
    logic        fl_rdy = 1'b1;

    int n_chk = 0;
    int n_err = 0;

    always #(CLK_P/2) clk = ~clk;

    smp_flash_writer #(
        .ADDR_W (AW), .BLK_W (BW), .FIFO_DEPTH (DEPTH),
        .WE_LOW (WL), .WE_HIGH (WH), .GUARD (GRD)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .smp_valid (smp_valid), .smp_data (smp_data),
        .fl_io (fl_io), .fl_io_oe (fl_io_oe), .fl_cle (fl_cle), .fl_ale (fl_ale),
        .fl_we_n (fl_we_n), .fl_rdy (fl_rdy), .ovf_flag (ovf_flag)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // flash model
    logic [7:0] fmem [MEMSZ];
    logic [7:0] emem [MEMSZ];
    int busy_cnt = 0;
    int mode = 0;
    int acnt = 0;
    int aacc = 0;
    int got_data = 0;
    logic [7:0] pdata = 8'h00;
    int prog_count = 0;
    int erase_count = 0;
    int exp_addr = 0;
    int low_run = 0;
    logic prev_we = 1'b1;

    always @(negedge clk) begin
        if (!rst_n) begin
            prev_we = 1'b1;
            busy_cnt = 0;
            fl_rdy = 1'b1;
        end else begin
            if (busy_cnt > 0) busy_cnt--;
            if (prev_we && !fl_we_n) begin
                check(busy_cnt == 0, "R5 pulse while busy", busy_cnt, 0);
            end
            if (!fl_we_n) low_run++;
            if (!prev_we && fl_we_n) begin
                check(low_run == WL, "R7 we low width", low_run, WL);
                low_run = 0;
                check(!(fl_cle && fl_ale), "R6 strobes exclusive", {fl_cle, fl_ale}, 0);
                if (fl_cle) begin
                    case (fl_io)
                        8'h80: begin mode = 1; acnt = 0; aacc = 0; got_data = 0; end
                        8'h60: begin mode = 2; acnt = 0; aacc = 0; got_data = 0; end
                        8'h10: begin
                            check(mode == 1 && acnt == ABYTES && got_data == 1,
                                  "R3 program sequence", acnt, ABYTES);
                            check(aacc == exp_addr, "R2 program address", aacc, exp_addr);
                            check(fmem[aacc % MEMSZ] == 8'hFF, "R4 erased before program",
                                  fmem[aacc % MEMSZ], 8'hFF);
                            fmem[aacc % MEMSZ] = fmem[aacc % MEMSZ] & pdata;
                            exp_addr = (exp_addr + 1) % MEMSZ;
                            prog_count++;
                            mode = 0;
                            busy_cnt = BUSYCYC;
                        end
                        8'hD0: begin
                            check(mode == 2 && acnt == ABYTES, "R4 erase sequence", acnt, ABYTES);
                            check((aacc % (1 << BW)) == 0 && aacc == exp_addr,
                                  "R4 erase block base", aacc, exp_addr);
                            for (int i = 0; i < (1 << BW); i++)
                                fmem[((aacc >> BW) << BW) + i] = 8'hFF;
                            erase_count++;
                            mode = 0;
                            busy_cnt = BUSYCYC;
                        end
                        default: check(1'b0, "R3 unknown command", fl_io, 8'h80);
                    endcase
                end else if (fl_ale) begin
                    aacc = aacc | (int'(fl_io) << (8 * acnt));
                    acnt++;
                end else begin
                    pdata = fl_io;
                    got_data = 1;
                end
            end
            prev_we = fl_we_n;
            fl_rdy = (busy_cnt == 0);
        end
    end

    // expected model
    int e_addr = 0;
    int pushed = 0;

    task automatic exp_byte(input logic [7:0] b);
        if ((e_addr % (1 << BW)) == 0)
            for (int i = 0; i < (1 << BW); i++) emem[e_addr + i] = 8'hFF;
        emem[e_addr] = b;
        e_addr = (e_addr + 1) % MEMSZ;
    endtask

    task automatic exp_word(input logic [31:0] w);
        exp_byte(w[31:24]);
        exp_byte(w[23:16]);
        exp_byte(w[15:8]);
        exp_byte(w[7:0]);
    endtask

    function automatic logic [31:0] pat(input int k);
        logic [15:0] l, r;
        l = 16'(k * 16'h0125 + 16'h3A07);
        r = 16'(~(k * 16'h00B3) ^ 16'h5C00);
        return {l, r};
    endfunction

    task automatic push_paced(input logic [31:0] w);
        while (pushed - prog_count / 4 >= DEPTH) @(negedge clk);
        smp_valid = 1'b1;
        smp_data = w;
        @(negedge clk);
        smp_valid = 1'b0;
        exp_word(w);
        pushed++;
    endtask

    task automatic drain();
        while (prog_count < 4 * pushed) @(negedge clk);
        repeat (BUSYCYC + GRD + 10) @(negedge clk);
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        n_err++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEMSZ; i++) begin fmem[i] = 8'h00; emem[i] = 8'h00; end
        repeat (3) @(negedge clk);
        // R9 reset state
        check(fl_we_n == 1'b1, "R9 we_n in reset", fl_we_n, 1);
        check(fl_cle == 1'b0 && fl_ale == 1'b0, "R9 strobes in reset", {fl_cle, fl_ale}, 0);
        check(fl_io_oe == 1'b0, "R9 oe in reset", fl_io_oe, 0);
        check(ovf_flag == 1'b0, "R9 ovf in reset", ovf_flag, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(fl_we_n == 1'b1 && fl_io_oe == 1'b0, "R9 idle after reset", fl_we_n, 1);

        // full pass plus wrap into block 0..4 (R1, R2, R4)
        for (int k = 0; k < MEMSZ / 4 + 40; k++) push_paced(pat(k));
        drain();
        check(ovf_flag == 1'b0, "R8 no overflow when paced", ovf_flag, 0);
        check(prog_count == 4 * pushed, "R2 program count", prog_count, 4 * pushed);

        // burst into a full FIFO (R8)
        for (int k = 0; k < 10; k++) begin
            smp_valid = 1'b1;
            smp_data = pat(1000 + k);
            @(negedge clk);
            if (k < DEPTH + 1) begin exp_word(pat(1000 + k)); pushed++; end
        end
        smp_valid = 1'b0;
        check(ovf_flag == 1'b1, "R8 overflow raised", ovf_flag, 1);
        drain();
        check(ovf_flag == 1'b1, "R8 overflow sticky", ovf_flag, 1);
        check(prog_count == 4 * pushed, "R8 dropped words not written", prog_count, 4 * pushed);
        check(erase_count == MEMSZ / (1 << BW) + 6, "R4 erase count",
              erase_count, MEMSZ / (1 << BW) + 6);

        // R1 contents of every address
        for (int a = 0; a < MEMSZ; a++)
            check(fmem[a] == emem[a], "R1 stored byte", fmem[a], emem[a]);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule